// File: doc/BRIEF.md
# Instruction Prefetch Aligner

The aligner sits between a 128-bit instruction cache read port and an instruction decoder. It fetches naturally aligned 16-byte blocks. It keeps them in a ring of 16-bit parcels and offers the decoder a fixed three-parcel (48-bit) window that begins at the current instruction address. After decoding, the decoder reports how many parcels it used: one, two or three. The window then moves forward by exactly that amount. An instruction that starts near the end of one block and ends in the next block is still presented as one whole window.

A redirect loads a new parcel-aligned instruction address. It empties the ring in the same cycle, cancels any block still on its way from the cache, and starts fetching again from the block that holds the target. Parcels in front of the target inside that first block are dropped. The cache is modelled as answering every request on the following clock edge.

Top module: `pfa_aligner`

## Requirements
- R1: During and just after synchronous reset, `win_valid` is low and `win_pc` is 0. In the first cycle after reset, `fetch_req` is high with `fetch_addr` = 0.
- R2: Every request carries a 16-byte-aligned `fetch_addr` (bits 3:0 zero). Requests without an intervening redirect go to ascending consecutive blocks.
- R3: Parcel k (k = 0..7) of a returned block sits at `fetch_data[127-16k -: 16]` and has byte address block base + 2k. `win_data[47:32]`, `[31:16]` and `[15:0]` hold the parcels at `win_pc`, `win_pc+2` and `win_pc+4`.
- R4: `consume_len` gives the consumed length in parcels: 1 = 16, 2 = 32, 3 = 48 bits. A consume in a valid cycle advances `win_pc` by 2·`consume_len` bytes at the next edge, and the new window starts at that address.
- R5: `win_valid` is high only while at least three parcels from `win_pc` onward are buffered. The decoder asserts `consume` only in valid cycles, and only with a non-zero length.
- R6: An instruction that crosses a block boundary appears whole in one window.
- R7: While `consume` is low, a valid window keeps `win_pc` and `win_data` unchanged, and no parcel is lost.
- R8: A request is issued whenever the free ring space, counting the block in flight, is at least 8 parcels. The ring never holds more than 16 parcels. With no consumption after reset, exactly two requests are issued.
- R9: A redirect empties the ring in its own cycle. In the next cycle `win_valid` is low, `win_pc` equals the target, and `fetch_req` is high for the block that holds the target.
- R10: A block response that arrives in a redirect cycle is discarded.
- R11: Parcels below the target inside the first block are skipped. The first window is valid two cycles after the redirect cycle when the target's parcel offset is 0..5, and three cycles after when it is 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | output | 1 | Block request to the cache this cycle |
| fetch_addr | output | 32 | Byte address of the requested aligned block |
| fetch_valid | input | 1 | Cache returns a block this cycle |
| fetch_data | input | 128 | Returned block, lowest-address parcel in the top bits |
| redirect | input | 1 | Load a new instruction address |
| redirect_addr | input | 32 | Parcel-aligned redirect target |
| consume | input | 1 | Decoder used the current window |
| consume_len | input | 2 | Parcels used: 1, 2 or 3 |
| win_valid | output | 1 | Window holds three buffered parcels |
| win_pc | output | 32 | Byte address of the window's first parcel |
| win_data | output | 48 | Decode window, first parcel in the top bits |

## Verification
The cache answer is due one edge after a request. A consume shows up as the next window one edge later. After a redirect, `win_valid` falls at the next edge, and the first window arrives two or three edges after that, depending on the target's offset in its block. The bench drives every input on the falling edge. It reads outputs there, or 1 ns after the falling edge when a freshly driven input feeds `fetch_req` through logic. It counts falling edges from the redirect to the first valid window and compares that count to the offset rule. The scoreboard pops an expected window only after the edge that took the consume, so a stalled cycle must show the same entry again.

// File: rtl/pfa_pkg.sv
`timescale 1ns/1ps
package pfa_pkg;

    // Default geometry of the aligner
    localparam int unsigned ADDR_W_DEF      = 32;
    localparam int unsigned PARCEL_W_DEF    = 16;
    localparam int unsigned BLK_PARCELS_DEF = 8;
    localparam int unsigned Q_PARCELS_DEF   = 16;
    localparam int unsigned WIN_PARCELS_DEF = 3;

    // Byte distance covered by a length code counted in parcels
    function automatic int unsigned pfa_step_bytes(input logic [1:0] parcels,
                                                   input int unsigned parcel_bytes);
        return int'(parcels) * parcel_bytes;
    endfunction

endpackage

// File: rtl/pfa_fetch_ctl.sv
`timescale 1ns/1ps
module pfa_fetch_ctl #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned PARCEL_W    = 16,
    parameter int unsigned BLK_PARCELS = 8,
    parameter int unsigned Q_PARCELS   = 16,
    localparam int unsigned CNT_W      = $clog2(Q_PARCELS + 1),
    localparam int unsigned BLK_BYTES  = BLK_PARCELS * PARCEL_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic [CNT_W-1:0]  occ,
    input  logic              fetch_valid,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              accept
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_BYTES - 1);
    localparam logic [CNT_W:0]    REQ_LIMIT = (CNT_W + 1)'(Q_PARCELS - BLK_PARCELS);

    logic [ADDR_W-1:0] next_blk_q;
    logic              inflight_q;
    logic [CNT_W:0]    claimed;

    // Parcels held plus parcels already promised by the block in flight
    assign claimed   = {1'b0, occ} + (inflight_q ? (CNT_W + 1)'(BLK_PARCELS) : '0);
    assign fetch_req = !redirect && (claimed <= REQ_LIMIT);
    assign fetch_addr = next_blk_q;
    assign accept    = fetch_valid && inflight_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_blk_q <= '0;
            inflight_q <= 1'b0;
        end else if (redirect) begin
            next_blk_q <= redirect_addr & BLK_MASK;
            inflight_q <= 1'b0;
        end else begin
            inflight_q <= fetch_req;
            if (fetch_req) begin
                next_blk_q <= next_blk_q + ADDR_W'(BLK_BYTES);
            end
        end
    end

endmodule

// File: rtl/pfa_parcel_queue.sv
`timescale 1ns/1ps
module pfa_parcel_queue #(
    parameter int unsigned PARCEL_W    = 16,
    parameter int unsigned BLK_PARCELS = 8,
    parameter int unsigned Q_PARCELS   = 16,
    parameter int unsigned WIN_PARCELS = 3,
    localparam int unsigned BLK_W      = PARCEL_W * BLK_PARCELS,
    localparam int unsigned WIN_W      = PARCEL_W * WIN_PARCELS,
    localparam int unsigned IDX_W      = $clog2(Q_PARCELS),
    localparam int unsigned CNT_W      = $clog2(Q_PARCELS + 1),
    localparam int unsigned SKIP_W     = $clog2(BLK_PARCELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [SKIP_W-1:0] flush_skip,
    input  logic              accept,
    input  logic [BLK_W-1:0]  blk,
    input  logic              take,
    input  logic [1:0]        take_len,
    output logic [CNT_W-1:0]  occ,
    output logic [WIN_W-1:0]  win,
    output logic              win_ok
);
    typedef struct packed {
        logic [IDX_W-1:0]  rd;
        logic [CNT_W-1:0]  cnt;
        logic [SKIP_W-1:0] skip;
    } qstate_t;

    qstate_t             st_q, st_n;
    logic [PARCEL_W-1:0] ring_q [Q_PARCELS];
    logic [IDX_W-1:0]    wr_idx;
    logic [CNT_W-1:0]    gain, loss;
    logic [IDX_W-1:0]    rd_gain, rd_loss;

    assign wr_idx  = st_q.rd + IDX_W'(st_q.cnt);
    assign gain    = accept ? (CNT_W'(BLK_PARCELS) - CNT_W'(st_q.skip)) : '0;
    assign loss    = take ? CNT_W'(take_len) : '0;
    assign rd_gain = accept ? IDX_W'(st_q.skip) : '0;
    assign rd_loss = take ? IDX_W'(take_len) : '0;

    always_comb begin
        st_n = st_q;
        if (flush) begin
            st_n.cnt  = '0;
            st_n.skip = flush_skip;
        end else begin
            st_n.cnt = st_q.cnt + gain - loss;
            st_n.rd  = st_q.rd + rd_gain + rd_loss;
            if (accept) begin
                st_n.skip = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_n;
        end
    end

    // Whole block lands behind the newest parcel; leading skip is dropped by moving rd
    always_ff @(posedge clk) begin
        if (accept && !flush) begin
            for (int i = 0; i < int'(BLK_PARCELS); i++) begin
                ring_q[wr_idx + IDX_W'(i)] <= blk[BLK_W - 1 - i * PARCEL_W -: PARCEL_W];
            end
        end
    end

    for (genvar w = 0; w < int'(WIN_PARCELS); w++) begin : g_win
        assign win[WIN_W - 1 - w * PARCEL_W -: PARCEL_W] = ring_q[st_q.rd + IDX_W'(w)];
    end

    assign win_ok = st_q.cnt >= CNT_W'(WIN_PARCELS);
    assign occ    = st_q.cnt;

endmodule

// File: rtl/pfa_aligner.sv
`timescale 1ns/1ps
module pfa_aligner #(
    parameter int unsigned ADDR_W      = pfa_pkg::ADDR_W_DEF,
    parameter int unsigned PARCEL_W    = pfa_pkg::PARCEL_W_DEF,
    parameter int unsigned BLK_PARCELS = pfa_pkg::BLK_PARCELS_DEF,
    parameter int unsigned Q_PARCELS   = pfa_pkg::Q_PARCELS_DEF,
    parameter int unsigned WIN_PARCELS = pfa_pkg::WIN_PARCELS_DEF,
    localparam int unsigned FETCH_W    = PARCEL_W * BLK_PARCELS,
    localparam int unsigned WIN_W      = PARCEL_W * WIN_PARCELS,
    localparam int unsigned CNT_W      = $clog2(Q_PARCELS + 1),
    localparam int unsigned PB         = PARCEL_W / 8,
    localparam int unsigned PB_W       = $clog2(PB),
    localparam int unsigned SKIP_W     = $clog2(BLK_PARCELS),
    localparam int unsigned OFF_W      = PB_W + SKIP_W
) (
    input  logic               clk,
    input  logic               rst,
    output logic               fetch_req,
    output logic [ADDR_W-1:0]  fetch_addr,
    input  logic               fetch_valid,
    input  logic [FETCH_W-1:0] fetch_data,
    input  logic               redirect,
    input  logic [ADDR_W-1:0]  redirect_addr,
    input  logic               consume,
    input  logic [1:0]         consume_len,
    output logic               win_valid,
    output logic [ADDR_W-1:0]  win_pc,
    output logic [WIN_W-1:0]   win_data
);
    localparam logic [ADDR_W-1:0] PC_MASK = ~ADDR_W'(PB - 1);

    logic             blk_accept;
    logic [CNT_W-1:0] q_occ;
    logic             q_ok;
    logic             take;
    logic [ADDR_W-1:0] pc_q;

    assign take = consume && q_ok && !redirect;

    pfa_fetch_ctl #(
        .ADDR_W(ADDR_W), .PARCEL_W(PARCEL_W),
        .BLK_PARCELS(BLK_PARCELS), .Q_PARCELS(Q_PARCELS)
    ) u_fetch (
        .clk(clk), .rst(rst),
        .redirect(redirect), .redirect_addr(redirect_addr),
        .occ(q_occ), .fetch_valid(fetch_valid),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .accept(blk_accept)
    );

    pfa_parcel_queue #(
        .PARCEL_W(PARCEL_W), .BLK_PARCELS(BLK_PARCELS),
        .Q_PARCELS(Q_PARCELS), .WIN_PARCELS(WIN_PARCELS)
    ) u_queue (
        .clk(clk), .rst(rst),
        .flush(redirect), .flush_skip(redirect_addr[OFF_W-1:PB_W]),
        .accept(blk_accept), .blk(fetch_data),
        .take(take), .take_len(consume_len),
        .occ(q_occ), .win(win_data), .win_ok(q_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (redirect) begin
            pc_q <= redirect_addr & PC_MASK;
        end else if (take) begin
            pc_q <= pc_q + ADDR_W'(pfa_pkg::pfa_step_bytes(consume_len, PB));
        end
    end

    assign win_valid = q_ok;
    assign win_pc    = pc_q;

endmodule

// File: rtl/pfa_aligner_chk.sv
`timescale 1ns/1ps
module pfa_aligner_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned WIN_W     = 48,
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned Q_PARCELS = 16,
    parameter int unsigned BLK_BYTES = 16,
    parameter int unsigned PB        = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              redirect,
    input logic [ADDR_W-1:0] redirect_addr,
    input logic              consume,
    input logic [1:0]        consume_len,
    input logic              win_valid,
    input logic [ADDR_W-1:0] win_pc,
    input logic [WIN_W-1:0]  win_data,
    input logic [CNT_W-1:0]  occ
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_BYTES - 1);
    localparam logic [ADDR_W-1:0] PC_MASK  = ~ADDR_W'(PB - 1);

    // R2
    fetch_align_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (fetch_addr & ~BLK_MASK) == '0);

    // R5
    consume_legal_chk: assert property (@(posedge clk) disable iff (rst)
        consume |-> win_valid && consume_len != 2'd0);

    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        consume && win_valid && !redirect |=>
            win_pc == $past(win_pc) + ADDR_W'(PB * $past(consume_len)));

    // R7
    hold_window_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid && !consume && !redirect |=>
            win_valid && $stable(win_data) && $stable(win_pc));

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !win_valid && win_pc == ($past(redirect_addr) & PC_MASK));

    // R9
    refetch_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |=> redirect || (fetch_req && fetch_addr == ($past(redirect_addr) & BLK_MASK)));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(Q_PARCELS));

endmodule

bind pfa_aligner pfa_aligner_chk #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .CNT_W(CNT_W),
    .Q_PARCELS(Q_PARCELS), .BLK_BYTES(BLK_PARCELS * PARCEL_W / 8), .PB(PB)
) u_chk (
    .clk(clk), .rst(rst),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .redirect(redirect), .redirect_addr(redirect_addr),
    .consume(consume), .consume_len(consume_len),
    .win_valid(win_valid), .win_pc(win_pc), .win_data(win_data),
    .occ(q_occ)
);

// File: tb/sim_pfa_aligner.sv
`timescale 1ns/1ps
module sim_pfa_aligner;
    localparam int unsigned AW = 32;
    localparam int unsigned FW = 128;
    localparam int unsigned WW = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          fetch_valid;
    logic [FW-1:0] fetch_data;
    logic          redirect;
    logic [AW-1:0] redirect_addr;
    logic          consume;
    logic [1:0]    consume_len;
    logic          win_valid;
    logic [AW-1:0] win_pc;
    logic [WW-1:0] win_data;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] lfsr = 16'hACE1;

    typedef struct {
        logic [AW-1:0] pc;
        logic [WW-1:0] w;
        logic [1:0]    len;
    } item_t;
    item_t sb[$];

    pfa_aligner u0 (
        .clk(clk), .rst(rst),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .redirect(redirect), .redirect_addr(redirect_addr),
        .consume(consume), .consume_len(consume_len),
        .win_valid(win_valid), .win_pc(win_pc), .win_data(win_data)
    );

    always #10 clk = ~clk;

    // Instruction memory image: a hash of the parcel address
    function automatic logic [15:0] par_at(input logic [AW-1:0] a);
        logic [31:0] h;
        h = (a >> 1) * 32'h9E3779B1;
        return h[31:16] ^ h[15:0];
    endfunction

    // Bench-side decoder: instruction length in parcels from its first parcel
    function automatic logic [1:0] len_of(input logic [15:0] p);
        logic [15:0] m;
        m = (p % 16'd3) + 16'd1;
        return m[1:0];
    endfunction

    function automatic logic [FW-1:0] blk_at(input logic [AW-1:0] a);
        logic [FW-1:0] b;
        logic [AW-1:0] base;
        base = {a[AW-1:4], 4'h0};
        for (int i = 0; i < 8; i++) b[FW - 1 - 16 * i -: 16] = par_at(base + AW'(2 * i));
        return b;
    endfunction

    function automatic logic [WW-1:0] win_at(input logic [AW-1:0] pc);
        return {par_at(pc), par_at(pc + 2), par_at(pc + 4)};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cache model: answers each request one edge later
    initial begin
        logic          r;
        logic [AW-1:0] a;
        fetch_valid = 1'b0;
        fetch_data  = '0;
        forever begin
            @(negedge clk);
            #2;
            r = fetch_req;
            a = fetch_addr;
            if (r && !rst) chk("R2 request aligned", {60'd0, a[3:0]}, 64'd0);
            @(posedge clk);
            #1;
            fetch_valid = r;
            fetch_data  = blk_at(a);
        end
    end

    // Driver: expected windows for a stream starting at start
    task automatic push_stream(input logic [AW-1:0] start, input int n);
        logic [AW-1:0] pc;
        pc = start;
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.pc  = pc;
            it.w   = win_at(pc);
            it.len = len_of(par_at(pc));
            sb.push_back(it);
            pc = pc + AW'(2 * it.len);
        end
    endtask

    // Monitor: compare each presented window against the scoreboard head
    task automatic drain();
        int    idle = 0;
        bit    stalled = 1'b0;
        bit    go;
        string tag;
        while (sb.size() > 0 && idle < 12) begin
            go = 1'b0;
            consume = 1'b0;
            if (win_valid) begin
                idle = 0;
                if (stalled) tag = "R7";
                else if (sb[0].pc[3:1] >= 3'd6) tag = "R6";
                else tag = "R4";
                chk({tag, " window pc"}, {32'd0, win_pc}, {32'd0, sb[0].pc});
                chk({tag, " R3 window data"}, {16'd0, win_data}, {16'd0, sb[0].w});
                go = (lfsr[1:0] != 2'b00);
                consume = go;
                consume_len = sb[0].len;
                stalled = !go;
            end else begin
                idle++;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(posedge clk);
            if (go) void'(sb.pop_front());
            @(negedge clk);
        end
        consume = 1'b0;
        if (idle >= 12) begin
            chk("R8 window starved", 64'd1, 64'd0);
            sb.delete();
        end
    endtask

    task automatic jump(input logic [AW-1:0] tgt, input bit via_decoy, input logic [AW-1:0] decoy);
        int k = 0;
        int exp_k;
        consume = 1'b0;
        if (via_decoy) begin
            redirect = 1'b1;
            redirect_addr = decoy;
            @(negedge clk);
            redirect = 1'b0;
            #1;
            chk("R10 decoy block requested", {63'd0, fetch_req}, 64'd1);
            @(negedge clk);
        end
        redirect = 1'b1;
        redirect_addr = tgt;
        @(negedge clk);
        redirect = 1'b0;
        #1;
        chk("R9 window invalid after flush", {63'd0, win_valid}, 64'd0);
        chk("R9 pc loaded", {32'd0, win_pc}, {32'd0, tgt});
        chk("R9 refetch requested", {63'd0, fetch_req}, 64'd1);
        chk("R9 refetch block", {32'd0, fetch_addr}, {32'd0, tgt[AW-1:4], 4'h0});
        while (!win_valid && k < 8) begin
            @(negedge clk);
            k++;
        end
        exp_k = (tgt[3:1] <= 3'd5) ? 2 : 3;
        chk("R11 R5 first window latency", 64'(k), 64'(exp_k));
        push_stream(tgt, 50);
        drain();
    endtask

    initial begin
        int reqs = 0;
        redirect = 1'b0;
        redirect_addr = '0;
        consume = 1'b0;
        consume_len = 2'd0;
        repeat (3) @(negedge clk);
        chk("R1 window invalid in reset", {63'd0, win_valid}, 64'd0);
        rst = 1'b0;
        #1;
        chk("R1 first request", {63'd0, fetch_req}, 64'd1);
        chk("R1 first address", {32'd0, fetch_addr}, 64'd0);
        chk("R1 pc at zero", {32'd0, win_pc}, 64'd0);
        for (int i = 0; i < 10; i++) begin
            if (i < 2) chk("R5 no window before data", {63'd0, win_valid}, 64'd0);
            if (fetch_req) reqs++;
            @(negedge clk);
            #1;
        end
        chk("R8 fill stops at two blocks", 64'(reqs), 64'd2);
        chk("R8 window valid after fill", {63'd0, win_valid}, 64'd1);
        chk("R3 first window", {16'd0, win_data}, {16'd0, win_at(32'd0)});
        push_stream(32'd0, 80);
        drain();
        jump(32'h0000_1006, 1'b0, 32'd0);
        jump(32'h0002_000A, 1'b0, 32'd0);
        jump(32'h0003_000C, 1'b0, 32'd0);
        jump(32'h0004_000E, 1'b0, 32'd0);
        jump(32'h0006_0004, 1'b1, 32'h0005_0000);
        jump(32'h0007_FFF2, 1'b1, 32'h0001_0008);
        jump(32'h0000_0040, 1'b0, 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule